// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

This block produces the 16x oversampling strobe that paces a serial transmitter and receiver. Software programs a 16-bit value through a write strobe and selects one of two ways of using it. In divider mode the value is a whole number of clock cycles between strobes, equal to the clock frequency divided by sixteen times the baud rate. In accumulator mode the value is added every cycle to a 16-bit phase register, and a strobe is issued whenever that addition carries out. The strobe rate is then value x clock / 2^16, so the value equals baud x 16 x 2^16 / clock. This gives fine fractional rates.

Accumulator mode is the intended choice for 19200 baud and faster, because its rate error stays small. Divider mode is intended for slower rates. With a 200 MHz reference clock, 9600 baud needs a divider value of 1302, and 115200 baud needs an increment of about 604. A run control gates the generator. Software clears run, writes a new value, picks the mode and sets run again. All control pins are plain levels, and no handshake is involved: the tick is a strobe that the consumer samples on the clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first cycle after it, tick is 0.
- R2: In divider mode (acc_mode = 0) with value N >= 1 and run_en held high, tick is high once every N cycles. The first strobe comes N cycles after the first clock edge at which run_en is sampled high.
- R3: In divider mode a programmed value of 0 produces no tick at all.
- R4: In accumulator mode (acc_mode = 1) with increment K, the count of ticks after W enabled clock edges is floor(W x K / 65536). Each tick marks a carry out of the 16-bit phase sum.
- R5: In accumulator mode an increment of 0 produces no tick at all.
- R6: While run_en is low, tick stays 0 and the count and phase are cleared. After run_en rises again, the first tick comes one full period later.
- R7: acc_mode selects the rate law: 1 gives the fractional accumulator rate of R4, and 0 gives the integer period of R2.
- R8: A value written while the generator runs is used only from the next reload in divider mode, or the next carry in accumulator mode. The period in progress is never shortened.
- R9: When the divider value is at least 2, or the increment is below 32768, tick is never high on two consecutive cycles.
- R10: The value register loads wr_data only on a cycle with wr_en high. wr_data has no effect on other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Generator enable; low clears the count and phase |
| acc_mode | input | 1 | 1 = fractional accumulator, 0 = integer divider |
| wr_en | input | 1 | Write strobe for the programmed value |
| wr_data | input | 16 | Divider period or accumulator increment |
| tick | output | 1 | Single-cycle 16x oversampling strobe |

## Verification
The divider is driven with random periods and with the edge values 1 and 0. Interval and first-strobe timing tell an off-by-one reload apart from a correct one. The accumulator is driven with random increments and with exact powers of two. The tick totals over long windows tell a wrong carry width or a lost remainder from the exact fractional rate. Further directed cases cover a write during a running period and writes without the strobe. They also cover clearing and restoring run_en, which separates deferred reload from immediate truncation and a stale phase from a cleared one.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic {
    MODE_DIVIDE = 1'b0,
    MODE_PHASE  = 1'b1
  } tick_mode_e;
endpackage

// File: rtl/bt_value_reg.sv
module bt_value_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     value_q <= '0;
    else if (wr_en) value_q <= wr_data;
  end

  // R10: value only moves on a strobed write
  assert_hold_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value_q));
endmodule

// File: rtl/bt_div_core.sv
module bt_div_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] prog,
  output logic         tick_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en || per_q == '0) begin
      cnt_q  <= '0;
      per_q  <= prog;
      tick_q <= 1'b0;
    end else if (cnt_q == per_q - ONE) begin
      cnt_q  <= '0;
      per_q  <= prog;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + ONE;
      tick_q <= 1'b0;
    end
  end

  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick_q && cnt_q == '0));
  assert_zero_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_q == '0) |=> !tick_q);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (cnt_q < per_q));
  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && per_q > ONE) |=> !tick_q);
endmodule

// File: rtl/bt_acc_core.sv
module bt_acc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] prog,
  output logic         tick_q
);
  localparam logic [W-1:0] HALF = W'(1) << (W - 1);

  logic [W-1:0] phase_q;
  logic [W-1:0] inc_q;
  logic [W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, inc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      inc_q   <= '0;
      tick_q  <= 1'b0;
    end else if (!en) begin
      phase_q <= '0;
      inc_q   <= prog;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= sum[W-1:0];
      tick_q  <= sum[W];
      if (sum[W] || inc_q == '0) inc_q <= prog;
    end
  end

  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tick_q && phase_q == '0));
  assert_zero_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc_q == '0) |=> !tick_q);
  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && inc_q < HALF) |=> !tick_q);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             acc_mode,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_data,
  output logic             tick
);
  import bt_pkg::*;

  tick_mode_e       mode;
  logic [VAL_W-1:0] value_q;
  logic             div_tick;
  logic             acc_tick;

  assign mode = tick_mode_e'(acc_mode);

  bt_value_reg #(.W(VAL_W)) u_value (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .value_q(value_q)
  );

  bt_div_core #(.W(VAL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(run_en && mode == MODE_DIVIDE),
    .prog(value_q), .tick_q(div_tick)
  );

  bt_acc_core #(.W(VAL_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(run_en && mode == MODE_PHASE),
    .prog(value_q), .tick_q(acc_tick)
  );

  assign tick = div_tick | acc_tick;

  // R7: only the selected law may ever produce a strobe
  assert_one_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_tick, acc_tick}));
  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !tick);
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        acc_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .acc_mode(acc_mode),
    .wr_en(wr_en), .wr_data(wr_data), .tick(tick)
  );

  function automatic int exp_div(int w, int n);
    return (n == 0) ? 0 : w / n;
  endfunction

  function automatic int exp_acc(int w, int k);
    longint p = longint'(w) * longint'(k);
    return int'(p >> 16);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_val(logic [15:0] v);
    @(negedge clk);
    wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Stop, program, select mode, then run for w edges; sampled at negedges.
  task automatic run_window(logic m, logic [15:0] v, int w,
                            output int ticks, output int first, output int maxrun);
    int run = 0;
    run_en = 1'b0;
    write_val(v);
    acc_mode = m;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    ticks = 0; first = -1; maxrun = 0;
    for (int e = 1; e <= w; e++) begin
      @(negedge clk);
      if (tick) begin
        ticks++; run++;
        if (first < 0) first = e;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
    run_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t, f, mr, n, k;
    int edges[4];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset tick", int'(tick), 0);

    // R2 directed and random periods
    run_window(1'b0, 16'd7, 70, t, f, mr);
    check("R2 count N=7", t, exp_div(70, 7));
    check("R2 first tick N=7", f, 7);
    run_window(1'b0, 16'd1, 20, t, f, mr);
    check("R2 count N=1", t, 20);
    for (int i = 0; i < 5; i++) begin
      n = 2 + int'($urandom_range(0, 40));
      run_window(1'b0, 16'(n), 300, t, f, mr);
      check("R2 random period count", t, exp_div(300, n));
      check("R2 random first tick", f, n);
      check("R9 divider width", mr, 1);
    end

    // R3 zero divider
    run_window(1'b0, 16'd0, 100, t, f, mr);
    check("R3 zero divider ticks", t, 0);

    // R4/R7 accumulator
    run_window(1'b1, 16'd16384, 40, t, f, mr);
    check("R7 accumulator law K=2^14", t, 10);
    check("R4 first carry K=2^14", f, 4);
    for (int i = 0; i < 5; i++) begin
      k = 1 + int'($urandom_range(0, 32000));
      run_window(1'b1, 16'(k), 2000, t, f, mr);
      check("R4 random increment count", t, exp_acc(2000, k));
      check("R9 accumulator width", mr, 1);
    end
    run_window(1'b1, 16'd604, 5000, t, f, mr);
    check("R4 fractional K=604", t, exp_acc(5000, 604));

    // R5 zero increment
    run_window(1'b1, 16'd0, 300, t, f, mr);
    check("R5 zero increment ticks", t, 0);

    // R6 restart after run low: phase cleared, full period again
    run_window(1'b1, 16'd20000, 5, t, f, mr);
    run_window(1'b1, 16'd20000, 4, t, f, mr);
    check("R6 restart first carry", f, 4);
    run_en = 1'b0;
    acc_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 idle tick low", int'(tick), 0);

    // R8 write during a running divider period
    write_val(16'd10);
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    begin
      int idx = 0;
      for (int e = 1; e <= 16; e++) begin
        if (e == 4) begin wr_data = 16'd3; wr_en = 1'b1; end
        else wr_en = 1'b0;
        @(negedge clk);
        if (tick && idx < 4) begin edges[idx] = e; idx++; end
      end
      wr_en = 1'b0;
      check("R8 current period kept", edges[0], 10);
      check("R8 new period applied", edges[1], 13);
      check("R8 new period repeats", edges[2], 16);
    end
    run_en = 1'b0;

    // R10 data without strobe ignored
    write_val(16'd5);
    wr_data = 16'd2;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    t = 0; f = -1;
    for (int e = 1; e <= 20; e++) begin
      @(negedge clk);
      if (tick) begin t++; if (f < 0) f = e; end
    end
    run_en = 1'b0;
    check("R10 unstrobed data ignored count", t, 4);
    check("R10 unstrobed data ignored first", f, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule